// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A request carries the virtual address, a write flag and a user-mode flag. The walker takes the frame number of the page directory from its base input and uses the top ten address bits to pick a directory entry. That entry names a page table, and the middle ten address bits pick an entry in it. The frame number from the table entry, joined with the twelve-bit page offset, is the physical address. Every page, directory and table is 4 KB, and every entry is one 32-bit word.

Each entry is checked as it arrives. The walker faults if the entry is not present, if a user-mode request reaches a supervisor-only entry, or if a write reaches a read-only entry. The fault result carries a cause code. When the walk succeeds, the walker writes back any entry whose accessed bit is clear, and it writes back the table entry of a write request whose dirty bit is clear. A walk that faults writes nothing. The walker handles one request at a time and uses a single memory port that holds each request until it is acknowledged.

The controller is a state machine with seven states:
- IDLE: waits for a request.
- RD_DIR: reads the directory entry.
- RD_TBL: reads the table entry.
- WB_DIR: writes back the directory entry.
- WB_TBL: writes back the table entry.
- DONE: reports a translation.
- FAULT: reports a fault.

Its transitions are:
- IDLE goes to RD_DIR when a request arrives.
- RD_DIR goes to FAULT on a failed check and to RD_TBL otherwise.
- RD_TBL goes to FAULT on a failed check. Otherwise it goes to WB_DIR if the directory entry needs an update, to WB_TBL if only the table entry needs one, and to DONE if neither does.
- WB_DIR goes to WB_TBL if the table entry needs an update and to DONE otherwise.
- WB_TBL goes to DONE.
- DONE and FAULT both return to IDLE.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req` and `done_valid` are 0.
- R2: The directory entry is read at byte address {base frame, vaddr[31:22], 2'b00}. The table entry is read at {directory entry[31:12], vaddr[21:12], 2'b00}.
- R3: A successful walk reports `done_fault`=0, `done_cause`=0 and `done_paddr` = {table entry[31:12], vaddr[11:0]}.
- R4: An entry whose bit 0 (present) is 0 faults on both reads and writes. A directory entry fault gives cause 1. A table entry fault gives cause 2. No memory write happens in either case.
- R5: If `req_user`=1 and bit 2 (user access allowed) of either entry is 0, the walk faults with cause 3 and writes nothing. The same entries translate normally for a supervisor request.
- R6: If `req_write`=1 and bit 1 (writable) of either entry is 0, the walk faults with cause 4 and writes nothing. At each level the checks are ordered: present first, then privilege, then writable. The directory level is checked before the table level.
- R7: On success, each entry with bit 5 (accessed) clear is written back with that bit set. The directory entry is written first, then the table entry. An entry whose accessed bit is already set is not written for that reason.
- R8: On a successful write request, a table entry with bit 6 (dirty) clear is written back with that bit set. A read request never sets the dirty bit.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the walk ends. Any `req_valid` seen during that time is ignored.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable while a memory request waits for `mem_ack`.
- R11: `done_valid` is a one-cycle pulse, and `req_ready` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_ready | output | 1 | The walker is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user-mode access, 0 = supervisor access |
| dir_frame | input | 20 | Frame number of the page directory |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Write-back entry value |
| mem_ack | input | 1 | Access complete; read data is valid |
| mem_rdata | input | 32 | Read data |
| done_valid | output | 1 | One-cycle result pulse |
| done_fault | output | 1 | 1 = the walk faulted |
| done_cause | output | 3 | 0 none, 1 directory entry not present, 2 table entry not present, 3 privilege, 4 read-only |
| done_paddr | output | 32 | Physical address (0 when the walk faults) |

## Verification
A wrong state or a wrong stored entry in this block shows up in one of two places. It may show as a wrong address, a missing write or an extra write on the memory port, which is visible within a cycle of the memory acknowledge. It may instead show as a wrong cause or physical address in the `done_valid` pulse, which arrives a few cycles later. The bench checks both places. It counts the write-backs of each walk and reads the stored entries back after both faulting and successful walks. It varies the memory latency so that a request that does not hold steady is caught while it waits.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_WB_DIR,
        ST_WB_TBL,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_DIR_NP = 3'd1,
        FC_TBL_NP = 3'd2,
        FC_PRIV   = 3'd3,
        FC_RO     = 3'd4
    } fault_e;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;

endpackage

// File: rtl/pgwalk_check.sv
module pgwalk_check
    import pgwalk_pkg::*;
#(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             is_table,
    input  logic             acc_user,
    input  logic             acc_write,
    output logic             fault,
    output logic [2:0]       cause,
    output logic             need_upd,
    output logic [ENT_W-1:0] upd_entry
);

    logic [ENT_W-1:0] set_mask;

    always_comb begin
        fault = 1'b1;
        if (!entry[BIT_PRESENT]) begin
            cause = is_table ? FC_TBL_NP : FC_DIR_NP;
        end else if (acc_user && !entry[BIT_USER]) begin
            cause = FC_PRIV;
        end else if (acc_write && !entry[BIT_WRITE]) begin
            cause = FC_RO;
        end else begin
            cause = FC_NONE;
            fault = 1'b0;
        end

        set_mask = '0;
        set_mask[BIT_ACC] = 1'b1;
        if (is_table && acc_write) begin
            set_mask[BIT_DIRTY] = 1'b1;
        end
        need_upd  = (entry & set_mask) != set_mask;
        upd_entry = entry | set_mask;
    end

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
    import pgwalk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [VA_W-OFF_W-1:0] dir_frame,
    output logic             mem_req,
    output logic             mem_we,
    output logic [VA_W-1:0]  mem_addr,
    output logic [VA_W-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [VA_W-1:0]  mem_rdata,
    output logic             chk_table,
    output logic             chk_user,
    output logic             chk_write,
    input  logic             chk_fault,
    input  logic [2:0]       chk_cause,
    input  logic             chk_need,
    input  logic [VA_W-1:0]  chk_upd,
    output logic             done_valid,
    output logic             done_fault,
    output logic [2:0]       done_cause,
    output logic [VA_W-1:0]  done_paddr
);

    localparam int FRAME_W = VA_W - OFF_W;
    localparam int ENT_SH  = OFF_W - IDX_W;

    walk_st_e           state;
    logic [VA_W-1:0]    va_q;
    logic               wr_q;
    logic               usr_q;
    logic [FRAME_W-1:0] base_q;
    logic [FRAME_W-1:0] tbl_frame_q;
    logic [FRAME_W-1:0] page_frame_q;
    logic [VA_W-1:0]    pde_upd_q;
    logic [VA_W-1:0]    pte_upd_q;
    logic               pde_need_q;
    logic               pte_need_q;
    logic [2:0]         cause_q;

    logic [VA_W-1:0]    dir_addr;
    logic [VA_W-1:0]    tbl_addr;

    assign dir_addr = {base_q, va_q[VA_W-1 -: IDX_W], {ENT_SH{1'b0}}};
    assign tbl_addr = {tbl_frame_q, va_q[OFF_W +: IDX_W], {ENT_SH{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            va_q         <= '0;
            wr_q         <= 1'b0;
            usr_q        <= 1'b0;
            base_q       <= '0;
            tbl_frame_q  <= '0;
            page_frame_q <= '0;
            pde_upd_q    <= '0;
            pte_upd_q    <= '0;
            pde_need_q   <= 1'b0;
            pte_need_q   <= 1'b0;
            cause_q      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                        base_q <= dir_frame;
                        state  <= ST_RD_DIR;
                    end
                end
                ST_RD_DIR: begin
                    if (mem_ack) begin
                        if (chk_fault) begin
                            cause_q <= chk_cause;
                            state   <= ST_FAULT;
                        end else begin
                            tbl_frame_q <= mem_rdata[VA_W-1 -: FRAME_W];
                            pde_upd_q   <= chk_upd;
                            pde_need_q  <= chk_need;
                            state       <= ST_RD_TBL;
                        end
                    end
                end
                ST_RD_TBL: begin
                    if (mem_ack) begin
                        if (chk_fault) begin
                            cause_q <= chk_cause;
                            state   <= ST_FAULT;
                        end else begin
                            page_frame_q <= mem_rdata[VA_W-1 -: FRAME_W];
                            pte_upd_q    <= chk_upd;
                            pte_need_q   <= chk_need;
                            if (pde_need_q) begin
                                state <= ST_WB_DIR;
                            end else if (chk_need) begin
                                state <= ST_WB_TBL;
                            end else begin
                                state <= ST_DONE;
                            end
                        end
                    end
                end
                ST_WB_DIR: begin
                    if (mem_ack) begin
                        state <= pte_need_q ? ST_WB_TBL : ST_DONE;
                    end
                end
                ST_WB_TBL: begin
                    if (mem_ack) begin
                        state <= ST_DONE;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        done_valid = 1'b0;
        done_fault = 1'b0;
        done_cause = FC_NONE;
        done_paddr = '0;
        chk_table  = (state == ST_RD_TBL);
        chk_user   = usr_q;
        chk_write  = wr_q;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_RD_DIR: begin
                mem_req  = 1'b1;
                mem_addr = dir_addr;
            end
            ST_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
            end
            ST_WB_DIR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_addr;
                mem_wdata = pde_upd_q;
            end
            ST_WB_TBL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = pte_upd_q;
            end
            ST_DONE: begin
                done_valid = 1'b1;
                done_paddr = {page_frame_q, va_q[OFF_W-1:0]};
            end
            ST_FAULT: begin
                done_valid = 1'b1;
                done_fault = 1'b1;
                done_cause = cause_q;
            end
            default: ;
        endcase
    end

    // R10: a pending memory request holds steady until acknowledged
    a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11: the result pulse lasts one cycle and is followed by readiness
    a_r11_pulse_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (req_ready && !done_valid));

    // R9: no new request is accepted while memory traffic is in flight
    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R4: a fault always carries a non-zero cause
    a_r4_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault) |-> (done_cause != 3'd0));

    // R7: every write-back carries the accessed bit set
    a_r7_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_ACC]);

    // R3: a successful result carries cause zero
    a_r3_ok_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_fault) |-> (done_cause == 3'd0));

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int IDX_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    input  logic                  req_user,
    input  logic [VA_W-OFF_W-1:0] dir_frame,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [VA_W-1:0]       mem_addr,
    output logic [VA_W-1:0]       mem_wdata,
    input  logic                  mem_ack,
    input  logic [VA_W-1:0]       mem_rdata,
    output logic                  done_valid,
    output logic                  done_fault,
    output logic [2:0]            done_cause,
    output logic [VA_W-1:0]       done_paddr
);

    logic            chk_table;
    logic            chk_user;
    logic            chk_write;
    logic            chk_fault;
    logic [2:0]      chk_cause;
    logic            chk_need;
    logic [VA_W-1:0] chk_upd;

    pgwalk_check #(.ENT_W(VA_W)) u_check (
        .entry     (mem_rdata),
        .is_table  (chk_table),
        .acc_user  (chk_user),
        .acc_write (chk_write),
        .fault     (chk_fault),
        .cause     (chk_cause),
        .need_upd  (chk_need),
        .upd_entry (chk_upd)
    );

    pgwalk_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .req_user   (req_user),
        .dir_frame  (dir_frame),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .chk_table  (chk_table),
        .chk_user   (chk_user),
        .chk_write  (chk_write),
        .chk_fault  (chk_fault),
        .chk_cause  (chk_cause),
        .chk_need   (chk_need),
        .chk_upd    (chk_upd),
        .done_valid (done_valid),
        .done_fault (done_fault),
        .done_cause (done_cause),
        .done_paddr (done_paddr)
    );

endmodule

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;

    localparam logic [31:0] FP = 32'h01, FW = 32'h02, FU = 32'h04, FA = 32'h20, FD = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [19:0] dir_frame = 20'h00010;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_valid, done_fault;
    logic [2:0]  done_cause;
    logic [31:0] done_paddr;

    pgwalk_top i_pgwalk_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .dir_frame(dir_frame), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done_valid(done_valid), .done_fault(done_fault),
        .done_cause(done_cause), .done_paddr(done_paddr)
    );

    always #4 clk = ~clk;

    int vectors = 0;
    int errors  = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model
    logic [31:0] mem [int unsigned];
    int lat = 0;
    int wcnt = 0;
    int wr_cnt = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a[31:2])) return mem[a[31:2]];
        return 32'h0;
    endfunction

    function automatic logic [31:0] pe(input logic [19:0] fr, input logic [31:0] fl);
        return {fr, 12'h000} | fl;
    endfunction

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (rst_n && mem_req) begin
            if (wcnt >= lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= rd(mem_addr);
                if (mem_we) begin
                    mem[mem_addr[31:2]] = mem_wdata;
                    wr_cnt = wr_cnt + 1;
                end
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // scoreboard
    typedef struct {
        logic        fault;
        logic [2:0]  cause;
        logic [31:0] paddr;
        int          nwr;
        int          wbase;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    bit          prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    bit          last_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (last_done) check(req_ready == 1'b1, "R11 ready after pulse", 32'(req_ready), 32'd1);
            last_done = done_valid;
            if (prev_wait && mem_req) check(mem_addr == prev_addr, "R10 address held", mem_addr, prev_addr);
            prev_wait = mem_req && !mem_ack;
            prev_addr = mem_addr;
            if (done_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result", 32'(done_cause), 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(done_fault == e.fault, {e.tag, " fault flag"}, 32'(done_fault), 32'(e.fault));
                    check(done_cause == e.cause, {e.tag, " cause"}, 32'(done_cause), 32'(e.cause));
                    if (!e.fault) check(done_paddr == e.paddr, {e.tag, " paddr"}, done_paddr, e.paddr);
                    check((wr_cnt - e.wbase) == e.nwr, {e.tag, " write count"}, 32'(wr_cnt - e.wbase), 32'(e.nwr));
                end
            end
        end
    end

    task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                        input bit ef, input logic [2:0] ec, input logic [31:0] ep,
                        input int nwr, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.fault = ef; e.cause = ec; e.paddr = ep; e.nwr = nwr; e.wbase = wr_cnt; e.tag = tag;
        exp_q.push_back(e);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // page tables; directory at 0x10000
        mem[32'h10004 >> 2] = pe(20'h00020, FP|FW|FU|FA);
        mem[32'h20008 >> 2] = pe(20'h00777, FP|FW|FU|FA|FD);
        mem[32'h10008 >> 2] = pe(20'h00021, FP|FW|FU);
        mem[32'h2100C >> 2] = pe(20'h00555, FP|FW|FU);
        mem[32'h10010 >> 2] = pe(20'h00022, FP|FW|FU);
        mem[32'h22000 >> 2] = pe(20'h00999, FW|FU);
        mem[32'h10014 >> 2] = pe(20'h00023, FP|FW|FU);
        mem[32'h23004 >> 2] = pe(20'h00888, FP|FW);
        mem[32'h10018 >> 2] = pe(20'h00024, FP|FU|FA);
        mem[32'h24000 >> 2] = pe(20'h00abc, FP|FW|FU|FA);
        mem[32'h1001C >> 2] = pe(20'h00025, FP);

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        check(mem_req == 1'b0, "R1 no mem_req", 32'(mem_req), 32'd0);
        check(done_valid == 1'b0, "R1 no done", 32'(done_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !mem_req, "R1 idle after reset", 32'(req_ready), 32'd1);

        // R2 R3: bits already set, no write-backs
        walk(32'h0040_2345, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0077_7345, 0, "R2 R3 plain read");
        lat = 3;
        walk(32'h0040_2345, 1'b1, 1'b1, 1'b0, 3'd0, 32'h0077_7345, 0, "R3 slow write R10");

        // R7 accessed write-backs, R8 read leaves dirty clear
        walk(32'h0080_3010, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0055_5010, 2, "R7 read sets accessed");
        check(rd(32'h10008) == pe(20'h21, FP|FW|FU|FA), "R7 dir entry updated", rd(32'h10008), pe(20'h21, FP|FW|FU|FA));
        check(rd(32'h2100C) == pe(20'h555, FP|FW|FU|FA), "R8 read no dirty", rd(32'h2100C), pe(20'h555, FP|FW|FU|FA));
        lat = 0;
        walk(32'h0080_3010, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0055_5010, 0, "R7 no rewrite when set");
        walk(32'h0080_3010, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0055_5010, 1, "R8 write sets dirty");
        check(rd(32'h2100C) == pe(20'h555, FP|FW|FU|FA|FD), "R8 table dirty", rd(32'h2100C), pe(20'h555, FP|FW|FU|FA|FD));
        walk(32'h0080_3010, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0055_5010, 0, "R8 dirty already set");

        // R4 not present
        walk(32'h00C0_0000, 1'b0, 1'b0, 1'b1, 3'd1, 32'h0, 0, "R4 dir not present read");
        walk(32'h00C0_0000, 1'b1, 1'b0, 1'b1, 3'd1, 32'h0, 0, "R4 dir not present write");
        walk(32'h0100_0abc, 1'b0, 1'b0, 1'b1, 3'd2, 32'h0, 0, "R4 table not present");
        check(rd(32'h10010) == pe(20'h22, FP|FW|FU), "R4 dir untouched", rd(32'h10010), pe(20'h22, FP|FW|FU));

        // R5 privilege
        lat = 2;
        walk(32'h0140_10f0, 1'b0, 1'b1, 1'b1, 3'd3, 32'h0, 0, "R5 user to supervisor");
        check(rd(32'h23004) == pe(20'h888, FP|FW), "R5 entry untouched", rd(32'h23004), pe(20'h888, FP|FW));
        walk(32'h0140_10f0, 1'b0, 1'b0, 1'b0, 3'd0, 32'h0088_80f0, 2, "R5 supervisor allowed");
        lat = 0;

        // R6 read-only and priority
        walk(32'h0180_0004, 1'b1, 1'b0, 1'b1, 3'd4, 32'h0, 0, "R6 write read-only");
        walk(32'h0180_0004, 1'b0, 1'b0, 1'b0, 3'd0, 32'h00ab_c004, 0, "R6 read of read-only");
        walk(32'h01C0_0000, 1'b1, 1'b1, 1'b1, 3'd3, 32'h0, 0, "R6 priority privilege first");

        // R9 busy: valid held with another address while walking
        begin
            exp_t e;
            @(negedge clk);
            e.fault = 1'b0; e.cause = 3'd0; e.paddr = 32'h0077_7345; e.nwr = 0; e.wbase = wr_cnt; e.tag = "R9 first request";
            exp_q.push_back(e);
            req_vaddr = 32'h0040_2345; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
            @(negedge clk);
            req_vaddr = 32'h00C0_0000;
            while (!done_valid) begin
                check(req_ready == 1'b0, "R9 not ready while busy", 32'(req_ready), 32'd0);
                @(negedge clk);
            end
            req_valid = 1'b0;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(done_valid == 1'b0 && req_ready == 1'b1, "R9 busy request ignored", 32'(done_valid), 32'd0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule